// File: doc/BRIEF.md
# Flow-Through Late-Write Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM built for full use of its data bus. Every control input is captured on the rising clock edge. A read returns its word within the same clock period: the registered address drives the storage array, and the array output flows straight to the read port. A write supplies its address and byte-lane enables on one edge and its data on the next enabled edge. Because of this late-write scheme, reads and writes can alternate on consecutive cycles with no idle turnaround slot.

A cycle is started by a low load/advance input. While that input is high, the block repeats the cycle type already in progress and steps through a four-beat burst. A mode input picks interleaved or linear burst ordering. Three chip selects allow depth expansion. An active-low clock enable freezes the whole pipeline. An asynchronous output enable gates only the read drivers. The bidirectional data pins are split into a write-data input, a read-data output and a drive-enable output, which a pad ring combines. The model holds 1024 words of 36 bits, arranged as four 9-bit byte lanes.

Top module: `ftSram`

## Requirements
- R1: After a rising edge with clock enable active, load low, all chip selects asserted and rwN high (read), rdDrive is high (if oeN is low) and rdData holds the addressed word during the following clock period, before the next rising edge.
- R2: After a rising edge that loads a write (rwN low), the word is taken from wrData on the next rising edge with clock enable active. rdDrive stays low during a write cycle.
- R3: Each active-low bit i of bweN, sampled with the address of a write beat, selects whether lane i (wrData bits 9i+8 down to 9i) is stored. Lanes whose bit is high keep their old contents.
- R4: A load is a deselect unless ce1N is low, ce2 is high and ce3N is low. A deselect neither drives the read port nor changes any stored word.
- R5: With load/advance high, the previous cycle type (read, write or deselect) continues with the next burst address. rwN and the chip selects are ignored on such edges.
- R6: With burstMode low (linear), beat n reads or writes the base address with its two low bits replaced by (base + n) mod 4. The upper bits do not change, and the fifth beat returns to the base.
- R7: With burstMode high (interleaved), beat n uses the base address with its two low bits XORed with n mod 4.
- R8: oeN acts without a clock. rdDrive equals (read cycle active) AND NOT oeN, and rdData is all zero whenever rdDrive is low.
- R9: An edge with clkEnN high changes nothing. A pending write waits and takes its data on the next enabled edge, and read output stays stable.
- R10: A read loaded on the same edge that supplies data for a pending write to the same address returns the new bytes merged with the untouched old bytes.
- R11: While rstN is low, the block is deselected: rdDrive is low, rdData is zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of control and address state |
| clkEnN | input | 1 | Synchronous clock enable, active low |
| ce1N | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3N | input | 1 | Chip select, active low |
| advLdN | input | 1 | Low: load new cycle; high: advance burst |
| rwN | input | 1 | High read, low write (sampled on load) |
| bweN | input | 4 | Active-low byte-lane write enables |
| addr | input | 10 | Word address |
| burstMode | input | 1 | High interleaved, low linear burst order |
| wrData | input | 36 | Write data, taken one enabled edge after its address |
| oeN | input | 1 | Asynchronous output enable, active low |
| rdData | output | 36 | Read data; zero when not driven |
| rdDrive | output | 1 | Read-driver enable for the pad (high = driving) |

## Verification
Read results are due in the clock period right after the edge that loads or advances the read. For that reason the bench samples every output 8 ns after each rising edge, which is after the registers settle and well before the next edge. A write becomes visible only through a later read. That read can be loaded on the very edge that carries the write data, so the reference model commits the write before it decodes the new cycle on the same edge. Clock-enable holds are modelled as edges that change no state. Output-enable behaviour is checked 1 ns after oeN toggles, with no clock edge in between, to show the path is asynchronous.

// File: rtl/ftSramPkg.sv
`timescale 1ns/1ps
package ftSramPkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cycKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;     // clock enable active this edge
    logic load;     // new base address this edge
    logic capture;  // the cycle starting this edge is a write
    logic commit;   // pending write data is stored this edge
    logic readOut;  // current cycle is a read
  } ctrlStrobe_t;

endpackage

// File: rtl/ftSramCtrl.sv
`timescale 1ns/1ps
module ftSramCtrl
  import ftSramPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkEnN,
  input  logic        ce1N,
  input  logic        ce2,
  input  logic        ce3N,
  input  logic        advLdN,
  input  logic        rwN,
  output ctrlStrobe_t strb
);

  cycKind_e kindQ, kindD;
  logic     pendQ;
  logic     selHit;

  assign selHit = !ce1N && ce2 && !ce3N;

  // cycle type decoded only on load; advance keeps the running type
  always_comb begin
    kindD = kindQ;
    if (!advLdN) begin
      if (!selHit)  kindD = CYC_IDLE;
      else if (rwN) kindD = CYC_READ;
      else          kindD = CYC_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= CYC_IDLE;
      pendQ <= 1'b0;
    end else if (!clkEnN) begin
      kindQ <= kindD;
      pendQ <= (kindD == CYC_WRITE);
    end
  end

  always_comb begin
    strb.step    = !clkEnN;
    strb.load    = !advLdN;
    strb.capture = (kindD == CYC_WRITE);
    strb.commit  = pendQ && !clkEnN;
    strb.readOut = (kindQ == CYC_READ);
  end

endmodule

// File: rtl/ftSramDp.sv
`timescale 1ns/1ps
module ftSramDp
  import ftSramPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES-1:0]         bweN,
  input  logic                     burstMode,
  input  logic [LANES*LANE_W-1:0]  wrData,
  input  logic                     oeN,
  output logic [LANES*LANE_W-1:0]  rdData,
  output logic                     rdDrive
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BEAT_W = 2;

  logic [ADDR_W-1:0] baseQ, baseD;
  logic [BEAT_W-1:0] beatQ, beatD;
  logic [BEAT_W-1:0] lowD;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] curAddrQ;
  logic [ADDR_W-1:0] pendAddrQ;
  logic [LANES-1:0]  pendMaskQ;
  logic [WORD_W-1:0] rdWord;

  // burst address: base upper bits, low bits combined with beat count
  always_comb begin
    baseD = strb.load ? addr : baseQ;
    beatD = strb.load ? '0 : BEAT_W'(beatQ + 1'b1);
    if (burstMode) lowD = baseD[BEAT_W-1:0] ^ beatD;
    else           lowD = baseD[BEAT_W-1:0] + beatD;
    nextAddr = {baseD[ADDR_W-1:BEAT_W], lowD};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ     <= '0;
      beatQ     <= '0;
      curAddrQ  <= '0;
      pendAddrQ <= '0;
      pendMaskQ <= '0;
    end else if (strb.step) begin
      baseQ    <= baseD;
      beatQ    <= beatD;
      curAddrQ <= nextAddr;
      if (strb.capture) begin
        pendAddrQ <= nextAddr;
        pendMaskQ <= ~bweN;
      end
    end
  end

  // one storage array per byte lane; write lands on the data edge
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strb.commit && pendMaskQ[g])
        laneMem[pendAddrQ] <= wrData[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = laneMem[curAddrQ];
  end

  assign rdDrive = strb.readOut && !oeN;
  assign rdData  = rdDrive ? rdWord : '0;

endmodule

// File: rtl/ftSram.sv
`timescale 1ns/1ps
module ftSram
  import ftSramPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    advLdN,
  input  logic                    rwN,
  input  logic [LANES-1:0]        bweN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    burstMode,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);

  ctrlStrobe_t strb;

  ftSramCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .clkEnN (clkEnN),
    .ce1N   (ce1N),
    .ce2    (ce2),
    .ce3N   (ce3N),
    .advLdN (advLdN),
    .rwN    (rwN),
    .strb   (strb)
  );

  ftSramDp #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (addr),
    .bweN      (bweN),
    .burstMode (burstMode),
    .wrData    (wrData),
    .oeN       (oeN),
    .rdData    (rdData),
    .rdDrive   (rdDrive)
  );

endmodule

// File: rtl/ftSramChk.sv
`timescale 1ns/1ps
module ftSramChk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              advLdN,
  input logic              rwN,
  input logic              oeN,
  input logic [WORD_W-1:0] rdData,
  input logic              rdDrive
);

  logic selOk;
  assign selOk = !ce1N && ce2 && !ce3N;

  p_hiz_when_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (!rdDrive && rdData == '0));

  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && !selOk) |=> !rdDrive);

  p_write_no_drive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && selOk && !rwN) |=> !rdDrive);

  p_read_drives_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advLdN && selOk && rwN) |=> (rdDrive == !oeN));

  p_burst_keeps_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && advLdN && rdDrive) |=> (rdDrive || oeN));

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(rdData) || !$stable(oeN)));

  always_comb begin
    if (!rstN) begin
      a_reset_idle_r11: assert (!rdDrive || $isunknown(rdDrive));
    end
  end

endmodule

bind ftSram ftSramChk #(.WORD_W(LANES*LANE_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .clkEnN (clkEnN),
  .ce1N   (ce1N),
  .ce2    (ce2),
  .ce3N   (ce3N),
  .advLdN (advLdN),
  .rwN    (rwN),
  .oeN    (oeN),
  .rdData (rdData),
  .rdDrive(rdDrive)
);

// File: tb/ftSram_tb.sv
`timescale 1ns/1ps
module ftSram_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnN = 1'b0;
  logic        ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic        advLdN = 1'b0;
  logic        rwN = 1'b1;
  logic [3:0]  bweN = 4'hF;
  logic [9:0]  addr = '0;
  logic        burstMode = 1'b0;
  logic [35:0] wrData = '0;
  logic        oeN = 1'b0;
  logic [35:0] rdData;
  logic        rdDrive;

  int    total = 0;
  int    bad = 0;
  string curTag = "R11";

  always #10 clk = ~clk;  // 50 MHz

  ftSram u_dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advLdN(advLdN), .rwN(rwN), .bweN(bweN), .addr(addr), .burstMode(burstMode),
    .wrData(wrData), .oeN(oeN), .rdData(rdData), .rdDrive(rdDrive)
  );

  // behavioural reference model
  logic [35:0] mMem   [1024];
  logic [3:0]  mKnown [1024];
  int          mKind;          // 0 idle, 1 read, 2 write
  logic [9:0]  mBase, mCur, mPAddr;
  logic [1:0]  mCnt;
  logic [3:0]  mPMask;
  bit          mPend;

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mMem[i] = '0;
      mKnown[i] = 4'h0;
    end
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mKind = 0; mPend = 0; mCnt = 0; mBase = 0; mCur = 0; mPAddr = 0; mPMask = 0;
    end else if (!clkEnN) begin
      if (mPend) begin
        for (int l = 0; l < 4; l++) begin
          if (mPMask[l]) begin
            mMem[mPAddr][l*9 +: 9] = wrData[l*9 +: 9];
            mKnown[mPAddr][l] = 1'b1;
          end
        end
      end
      if (!advLdN) begin
        mKind = (!ce1N && ce2 && !ce3N) ? (rwN ? 1 : 2) : 0;
        mBase = addr;
        mCnt  = 2'd0;
      end else begin
        mCnt = mCnt + 2'd1;
      end
      if (burstMode) mCur = {mBase[9:2], mBase[1:0] ^ mCnt};
      else           mCur = {mBase[9:2], 2'(mBase[1:0] + mCnt)};
      mPend  = (mKind == 2);
      mPAddr = mCur;
      mPMask = ~bweN;
    end
  end

  task automatic fail(input string what, input logic [35:0] act, input logic [35:0] exp);
    bad++;
    $display("FAIL %s %s: actual=%h expected=%h at %0t", curTag, what, act, exp, $time);
  endtask

  task automatic compare();
    logic        expDrive;
    logic [35:0] lm;
    expDrive = (mKind == 1) && !oeN;
    total++;
    if (rdDrive !== expDrive) fail("drive", 36'(rdDrive), 36'(expDrive));
    if (expDrive) begin
      lm = '0;
      for (int l = 0; l < 4; l++) if (mKnown[mCur][l]) lm[l*9 +: 9] = '1;
      total++;
      if (((rdData ^ mMem[mCur]) & lm) !== 36'd0) fail("data", rdData, mMem[mCur]);
    end else begin
      total++;
      if (rdData !== 36'd0) fail("idle data", rdData, 36'd0);
    end
  endtask

  // drive one cycle, clock it, check 8 ns after the edge
  task automatic step(input string tag, input bit ld, input bit rd, input logic [2:0] ceBad,
                      input logic [3:0] bw, input int a, input logic [35:0] wd,
                      input bit cke, input bit oe);
    curTag = tag;
    advLdN = !ld;
    rwN    = rd;
    ce1N   = ceBad[0];
    ce2    = !ceBad[1];
    ce3N   = ceBad[2];
    bweN   = bw;
    addr   = 10'(a);
    wrData = wd;
    clkEnN = !cke;
    oeN    = !oe;
    @(posedge clk);
    #8;
    compare();
  endtask

  function automatic logic [35:0] pat(input int a, input int salt);
    return 36'(a) * 36'h0_0401_0083 + 36'(salt * 977) + 36'h9_1234_5678;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    #8;
    total++;
    if (rdDrive !== 1'b0 || rdData !== 36'd0) fail("reset", {rdDrive, rdData[34:0]}, 36'd0);
    rstN = 1'b1;
    step("R11", 1, 1, 3'b001, 4'hF, 0, 0, 1, 1);

    // R2: back-to-back full writes, data one edge late
    for (int i = 0; i < 16; i++)
      step("R2", 1, 0, 3'b000, 4'h0, i, (i == 0) ? 36'd0 : pat(i - 1, 1), 1, 1);
    step("R2", 1, 1, 3'b010, 4'hF, 0, pat(15, 1), 1, 1);

    // R1: single reads
    for (int i = 15; i >= 0; i--)
      step("R1", 1, 1, 3'b000, 4'hF, i, 0, 1, 1);

    // R3 + R10: partial writes each followed at once by a read of the same word
    step("R3", 1, 0, 3'b000, 4'b1110, 5, 0, 1, 1);
    step("R10", 1, 1, 3'b000, 4'hF, 5, pat(5, 2), 1, 1);
    step("R3", 1, 0, 3'b000, 4'b0101, 5, 0, 1, 1);
    step("R10", 1, 1, 3'b000, 4'hF, 5, pat(5, 3), 1, 1);
    step("R3", 1, 0, 3'b000, 4'b1111, 5, 0, 1, 1);
    step("R3", 1, 1, 3'b000, 4'hF, 5, pat(5, 4), 1, 1);
    step("R3", 1, 0, 3'b000, 4'b0111, 6, 0, 1, 1);
    step("R10", 1, 1, 3'b000, 4'hF, 6, pat(6, 5), 1, 1);

    // R10: alternating write/read with no idle cycles
    for (int i = 0; i < 4; i++) begin
      step("R10", 1, 0, 3'b000, 4'h0, 20 + i, 0, 1, 1);
      step("R10", 1, 1, 3'b000, 4'hF, 20 + i, pat(20 + i, 6), 1, 1);
    end

    // R4: each chip select wrong in turn, write attempt then read back
    for (int c = 0; c < 3; c++) begin
      step("R4", 1, 0, 3'(1 << c), 4'h0, 3, 0, 1, 1);
      step("R4", 1, 1, 3'(1 << c), 4'hF, 3, pat(3, 9), 1, 1);
      step("R4", 1, 1, 3'b000, 4'hF, 3, 0, 1, 1);
    end

    // R5: advance after deselect stays deselected even with good selects
    step("R5", 1, 1, 3'b100, 4'hF, 7, 0, 1, 1);
    step("R5", 0, 1, 3'b000, 4'hF, 0, 0, 1, 1);
    step("R5", 0, 1, 3'b000, 4'hF, 0, 0, 1, 1);

    // R6: linear read burst from base 6, six beats to show wrap
    burstMode = 1'b0;
    step("R6", 1, 1, 3'b000, 4'hF, 6, 0, 1, 1);
    for (int b = 1; b < 6; b++) step("R6", 0, 0, 3'b111, 4'hF, 0, 0, 1, 1);

    // R5 + R6: linear write burst from base 9, rwN/selects ignored on advance
    step("R5", 1, 0, 3'b000, 4'h0, 9, 0, 1, 1);
    for (int b = 1; b < 4; b++) step("R5", 0, 1, 3'b101, 4'h0, 0, pat(b, 7), 1, 1);
    step("R5", 1, 1, 3'b000, 4'hF, 9, pat(4, 7), 1, 1);
    for (int b = 1; b < 5; b++) step("R6", 0, 0, 3'b000, 4'hF, 0, 0, 1, 1);

    // R7: interleaved read bursts from bases 5 and 10
    burstMode = 1'b1;
    step("R7", 1, 1, 3'b000, 4'hF, 5, 0, 1, 1);
    for (int b = 1; b < 6; b++) step("R7", 0, 1, 3'b000, 4'hF, 0, 0, 1, 1);
    step("R7", 1, 1, 3'b000, 4'hF, 10, 0, 1, 1);
    for (int b = 1; b < 4; b++) step("R7", 0, 1, 3'b000, 4'hF, 0, 0, 1, 1);
    burstMode = 1'b0;

    // R9: clock enable hold during pending write, then data on enabled edge
    step("R9", 1, 0, 3'b000, 4'h0, 12, 0, 1, 1);
    step("R9", 1, 1, 3'b000, 4'hF, 13, 36'hF_FFFF_FFFF, 0, 1);
    step("R9", 0, 1, 3'b000, 4'hF, 14, 36'h0_0000_0001, 0, 1);
    step("R9", 1, 1, 3'b000, 4'hF, 12, pat(12, 8), 1, 1);
    step("R9", 1, 1, 3'b000, 4'hF, 2, 0, 0, 1);
    step("R9", 1, 1, 3'b000, 4'hF, 2, 0, 0, 1);
    step("R9", 1, 1, 3'b000, 4'hF, 13, 0, 1, 1);

    // R8: asynchronous output enable, toggled between edges
    step("R8", 1, 1, 3'b000, 4'hF, 2, 0, 1, 1);
    curTag = "R8";
    oeN = 1'b1;
    #1;
    total++;
    if (rdDrive !== 1'b0 || rdData !== 36'd0) fail("oe off", rdData, 36'd0);
    oeN = 1'b0;
    #1;
    total++;
    if (rdDrive !== 1'b1 || rdData !== mMem[2]) fail("oe on", rdData, mMem[2]);
    step("R8", 0, 1, 3'b000, 4'hF, 0, 0, 1, 0);
    step("R8", 0, 1, 3'b000, 4'hF, 0, 0, 1, 1);
    step("R8", 1, 1, 3'b010, 4'hF, 0, 0, 1, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule